// File: doc/BRIEF.md
# Two-Source Indexed Element Shuffle

The block builds a 128-bit result in which every element is chosen from the 256-bit pool formed by two source vectors. The element is picked by an index that sits in the matching element of a control vector. Element width is 8, 16, 32 or 64 bits, selected per operation. The index is wrapped modulo twice the number of elements per vector. The lower half of the wrapped range addresses the `vk` source and the upper half addresses the `vj` source.

In byte mode the control is a dedicated third vector. In the wider modes the control is the old contents of the destination register, and the result then overwrites that register. A surrounding wrapper places the correct control vector on the single control port. The block takes every control element together with the sources in the same cycle, so a destination that also serves as control is never read half-updated.

The result is registered with one cycle of latency and carries a valid flag.

Top module: `perm2src_shuffle`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_data` is all zeros.
- R2: `out_valid` equals `in_valid` delayed by one clock. A result appears on `out_data` one clock after the cycle in which `in_valid` was 1.
- R3: While `in_valid` is 0, `out_data` holds its last value.
- R4: Size code 0 selects 8-bit elements (m = 16). Result byte i takes k = (control byte i) mod 32. It equals `vk` byte k when k < 16, and `vj` byte k−16 otherwise. A control byte of 0xFF selects `vj` byte 15.
- R5: Size code 1 selects 16-bit elements (m = 8). k = (low byte of control halfword i) mod 16. The result is `vk` halfword k when k < 8, and `vj` halfword k−8 otherwise.
- R6: Size code 2 selects 32-bit elements (m = 4). k = (low byte of control word i) mod 8. The result is `vk` word k when k < 4, and `vj` word k−4 otherwise.
- R7: Size code 3 selects 64-bit elements (m = 2). k = (low byte of control doubleword i) mod 4. The result is `vk` doubleword k when k < 2, and `vj` doubleword k−2 otherwise.
- R8: For elements wider than a byte, control bits above the low byte of each element have no effect on the result.
- R9: When the previous result is fed back as the control of the next operation (destination used as control), the new result follows R5–R7 applied to that previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_size | input | 2 | Element size code: 0=8, 1=16, 2=32, 3=64 bits |
| in_vj | input | 128 | Source selected by the upper index range |
| in_vk | input | 128 | Source selected by the lower index range |
| in_ctrl | input | 128 | Per-element index vector |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_data | output | 128 | Registered shuffle result |

## Verification
The hardest cases to reach are those that show whether the wrap and the source split are right at their edges. These are indices that land exactly on m or on 2m−1, and control bytes whose upper bits are all set, such as 0xFF. The stimulus drives such indices in every size mode and checks that they fall on the expected `vj` or `vk` element. A second hard case is feedback, where the destination serves as control. The bench reads the previous result from `out_data` and drives it as the next control, so the model confirms that the new result comes only from the old control value.

// File: rtl/perm2src_shuffle.sv
module perm2src_shuffle #(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_size,
  input  logic [DATA_W-1:0] in_vj,
  input  logic [DATA_W-1:0] in_vk,
  input  logic [DATA_W-1:0] in_ctrl,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  localparam int NSIZE = 4;

  logic [2*DATA_W-1:0] pool;
  logic [DATA_W-1:0]   res [NSIZE];
  logic [DATA_W-1:0]   pick;

  assign pool = {in_vj, in_vk};

  for (genvar s = 0; s < NSIZE; s++) begin : g_size
    localparam int EW = 8 << s;
    localparam int M  = DATA_W / EW;
    localparam logic [7:0] MODV = 8'(2 * M);
    for (genvar i = 0; i < M; i++) begin : g_elem
      logic [7:0] raw;
      logic [7:0] k;
      assign raw = in_ctrl[i*EW +: 8];
      assign k   = raw % MODV;
      assign res[s][i*EW +: EW] = pool[int'(k)*EW +: EW];
    end
  end

  assign pick = res[in_size];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= pick;
    end
  end

endmodule

module perm2src_shuffle_chk #(
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        in_size,
  input logic [DATA_W-1:0] in_vj,
  input logic [DATA_W-1:0] in_vk,
  input logic [DATA_W-1:0] in_ctrl,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R3
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));

  // R4
  byte_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_size == 2'd0 && in_ctrl[4:0] == 5'd0)
      |=> out_data[7:0] == $past(in_vk[7:0]));

  // R4
  byte_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_size == 2'd0 && in_ctrl[4:0] == 5'd31)
      |=> out_data[7:0] == $past(in_vj[DATA_W-1 -: 8]));

  // R7
  dword_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_size == 2'd3 && in_ctrl[1:0] == 2'd3)
      |=> out_data[63:0] == $past(in_vj[DATA_W-1 -: 64]));

  // R6
  word_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_size == 2'd2 && in_ctrl[2:0] == 3'd4)
      |=> out_data[31:0] == $past(in_vj[31:0]));

endmodule

bind perm2src_shuffle perm2src_shuffle_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/perm2src_shuffle_bench.sv
module perm2src_shuffle_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   in_size = 2'd0;
  logic [127:0] in_vj = '0;
  logic [127:0] in_vk = '0;
  logic [127:0] in_ctrl = '0;
  logic         out_valid;
  logic [127:0] out_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  perm2src_shuffle u_perm2src_shuffle (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_size(in_size),
    .in_vj(in_vj), .in_vk(in_vk), .in_ctrl(in_ctrl),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [127:0] model(int sz, logic [127:0] vj,
                                         logic [127:0] vk, logic [127:0] c);
    logic [127:0] r;
    int eb, m, k, src;
    eb = 1 << sz;
    m  = 16 / eb;
    r  = '0;
    for (int i = 0; i < m; i++) begin
      k = int'(c[i*eb*8 +: 8]) % (2 * m);
      for (int b = 0; b < eb; b++) begin
        if (k < m) begin
          src = k * eb + b;
          r[(i*eb+b)*8 +: 8] = vk[src*8 +: 8];
        end else begin
          src = (k - m) * eb + b;
          r[(i*eb+b)*8 +: 8] = vj[src*8 +: 8];
        end
      end
    end
    return r;
  endfunction

  function automatic logic [127:0] pat(logic [7:0] base, logic [7:0] step);
    logic [127:0] v;
    for (int b = 0; b < 16; b++) v[b*8 +: 8] = base + step * 8'(b);
    return v;
  endfunction

  task automatic check(string req, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic run_op(int sz, logic [127:0] vj, logic [127:0] vk,
                        logic [127:0] c, string req);
    @(negedge clk);
    in_size  = 2'(sz);
    in_vj    = vj;
    in_vk    = vk;
    in_ctrl  = c;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, 128'(out_valid), 128'd1);
    check(req, out_data, model(sz, vj, vk, c));
  endtask

  task automatic t_reset;
    check("R1 valid", 128'(out_valid), 128'd0);
    check("R1 data", out_data, 128'd0);
  endtask

  task automatic t_byte;
    logic [127:0] vj, vk;
    vk = pat(8'hA0, 8'd1);
    vj = pat(8'hB0, 8'd1);
    run_op(0, vj, vk, pat(8'd0, 8'd1), "R4 identity");
    run_op(0, vj, vk, pat(8'd16, 8'd1), "R4 upper range");
    run_op(0, vj, vk, {16{8'hFF}}, "R4 ff wrap");
    check("R4 ff to vj15", out_data, {16{8'hBF}});
    run_op(0, vj, vk, pat(8'd31, 8'd253), "R4 mixed wrap");
  endtask

  task automatic t_half;
    logic [127:0] vj, vk, c;
    vk = pat(8'h10, 8'd3);
    vj = pat(8'h80, 8'd5);
    c  = {16'h0007, 16'h0008, 16'h00FF, 16'h0010, 16'h000F, 16'h0000, 16'h0009, 16'h0003};
    run_op(1, vj, vk, c, "R5 boundaries");
    run_op(1, vj, vk, {8{16'h00FF}}, "R5 ff wrap");
  endtask

  task automatic t_word;
    logic [127:0] vj, vk, c;
    vk = pat(8'h20, 8'd7);
    vj = pat(8'h60, 8'd11);
    c  = {32'h0000_0003, 32'h0000_0004, 32'h0000_00FF, 32'h0000_000A};
    run_op(2, vj, vk, c, "R6 boundaries");
    run_op(2, vj, vk, {32'hDEAD_BE03, 32'hFFFF_FF04, 32'h1234_56FF, 32'hA5A5_A50A}, "R8 word high bits");
    check("R8 same as clean", out_data, model(2, vj, vk, c));
  endtask

  task automatic t_dword;
    logic [127:0] vj, vk;
    vk = pat(8'h01, 8'd9);
    vj = pat(8'hC1, 8'd13);
    run_op(3, vj, vk, {64'h0000_0000_0000_0001, 64'h0000_0000_0000_0002}, "R7 low split");
    run_op(3, vj, vk, {64'hFFFF_FFFF_FFFF_FF00, 64'hFFFF_FFFF_FFFF_FFFF}, "R7 R8 ff high bits");
    check("R7 top element", out_data, {vk[63:0], vj[127:64]});
  endtask

  task automatic t_hold;
    logic [127:0] keep;
    keep = out_data;
    @(negedge clk);
    in_size = 2'd0;
    in_vj = ~in_vj;
    in_vk = ~in_vk;
    in_ctrl = pat(8'd5, 8'd3);
    repeat (3) @(negedge clk);
    check("R3 hold", out_data, keep);
    check("R2 idle valid", 128'(out_valid), 128'd0);
  endtask

  task automatic t_feedback;
    logic [127:0] vj, vk, prev;
    vk = pat(8'h33, 8'd1);
    vj = pat(8'h77, 8'd1);
    run_op(1, vj, vk, {16'h0004, 16'h0002, 16'h0005, 16'h0001, 16'h0003, 16'h0006, 16'h0000, 16'h0007}, "R9 setup");
    prev = out_data;
    run_op(1, ~vj, ~vk, prev, "R9 feedback half");
    prev = out_data;
    run_op(2, vj, vk, prev, "R9 feedback word");
  endtask

  task automatic t_backtoback;
    logic [127:0] vj, vk, c1, c2;
    vk = pat(8'h40, 8'd1);
    vj = pat(8'h50, 8'd1);
    c1 = pat(8'd15, 8'd255);
    c2 = pat(8'd16, 8'd1);
    @(negedge clk);
    in_size = 2'd0; in_vj = vj; in_vk = vk; in_ctrl = c1; in_valid = 1'b1;
    @(negedge clk);
    check("R2 first", out_data, model(0, vj, vk, c1));
    in_ctrl = c2;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 second", out_data, model(0, vj, vk, c2));
    check("R2 second valid", 128'(out_valid), 128'd1);
    @(negedge clk);
    check("R2 valid drops", 128'(out_valid), 128'd0);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte();
    t_half();
    t_word();
    t_dword();
    t_hold();
    t_feedback();
    t_backtoback();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule